// File: doc/BRIEF.md
# Prescaled Serial Clock Generator

This block derives the serial bit clock for a synchronous serial shift engine from the peripheral clock. The division ratio is the product of two stages. The first stage is a prescaler that divides by a value from 1 to 32. The second stage is a power-of-two divider that is chosen by a 3-bit code, and one code bypasses it. The generator takes a 16-bit clock-select word, a run enable and the idle polarity of the clock. It drives the SCK pin waveform and gives the shift engine single-cycle strobes that mark each rising and each falling SCK edge, plus one bit-tick per SCK period.

The clock-select word and the polarity are captured on the clock edge at which the generator leaves the stopped state. They are then held for as long as the generator runs, so no register write can shorten or stretch an SCK phase. When run is released, the generator finishes the period already in progress and then parks SCK at the idle level. With the smallest ratio (prescale 1 and the bypass code), SCK is a gated copy of the peripheral clock. In that case all three strobes stay high for every cycle that carries an SCK pulse.

Top module: `serclk_gen`

## Requirements
- R1: While reset is asserted and after it, with run low, `sck`, `rise_stb`, `fall_stb` and `bit_tick` are all 0.
- R2: Bits 12:8 of `clk_sel` hold the prescale value P minus one, and bits 2:0 hold the divider code. Codes 0, 1, 2, 3 and 4 give a divider D of 2, 4, 8, 16 and 32. One SCK period lasts N = P*D peripheral clock cycles, from N = 2 up to N = 1024.
- R3: Divider codes 5 and 6 give the same divider as code 4, so D = 32.
- R4: Divider code 7 bypasses the divider (D = 1), so N = P.
- R5: For N >= 2, the first clock edge that sees `run` high while stopped is the start edge. SCK leaves the idle level on the next edge. Each period then keeps the active level for floor(N/2) cycles and the idle level for the remaining N - floor(N/2) cycles, so the two phases differ by at most one cycle.
- R6: The idle level of SCK equals `cpol`, and the active level is its inverse.
- R7: For N >= 2, `rise_stb` is high for exactly the one cycle in which SCK has just gone from 0 to 1, and `fall_stb` for the one cycle in which it has just gone from 1 to 0. The two strobes are never high together.
- R8: For N >= 2, `bit_tick` pulses once per SCK period, in the same cycle in which SCK returns to the idle level.
- R9: Changes to `clk_sel` and `cpol` while the generator runs have no effect on the running waveform. The values are sampled at the start edge.
- R10: When `run` falls, the period in progress completes with both of its phases at full length. After that, SCK stays idle and no strobe or tick is produced.
- R11: For N = 1, SCK is the peripheral clock gated to full high phases (inverted when `cpol` = 1), beginning one cycle after the start edge. `rise_stb`, `fall_stb` and `bit_tick` are high in every cycle that follows a pulse-carrying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 16 | Clock-select word: prescale minus one in 12:8, divider code in 2:0 |
| run | input | 1 | Start or keep generating SCK |
| cpol | input | 1 | Idle level of SCK |
| sck | output | 1 | Serial clock pin |
| rise_stb | output | 1 | One-cycle strobe on each rising SCK edge |
| fall_stb | output | 1 | One-cycle strobe on each falling SCK edge |
| bit_tick | output | 1 | One pulse per SCK period, at the trailing edge |

## Verification
A wrong prescaler or divider count shows at `sck` within the first period after the start edge. It appears as a phase that is too long or too short, and the per-sample waveform comparison catches it at most N cycles later. If the captured configuration is corrupted, the period length changes from the next period onward. If the edge-to-strobe pairing breaks, `rise_stb`, `fall_stb` and `bit_tick` drift out of alignment with the observed SCK transitions in the same cycle. A stop-control error shows as a truncated last period or as a pulse after the period end.

// File: rtl/serclk_pkg.sv
// Shared constants, config type and code decoding for the serial clock generator.
// Assumes the clock-select word layout described in the brief.
package serclk_pkg;

    localparam int REG_W    = 16;
    localparam int PRE_W    = 5;
    localparam int PRE_LSB  = 8;
    localparam int CODE_W   = 3;
    localparam int CODE_LSB = 0;
    localparam int MAX_LOG2 = 5;
    localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
    localparam int DIV_W    = MAX_LOG2;

    localparam logic [CODE_W-1:0] CODE_BYPASS  = CODE_W'(7);
    localparam logic [CODE_W-1:0] CODE_LAST_PW = CODE_W'(MAX_LOG2 - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre_m1;
        logic [LOG_W-1:0] log2;
        logic             pol;
    } sck_cfg_t;

    // Map a divider code to log2 of the divide ratio.
    function automatic logic [LOG_W-1:0] code_to_log2(input logic [CODE_W-1:0] code);
        if (code == CODE_BYPASS)
            return '0;
        else if (code > CODE_LAST_PW)
            return LOG_W'(MAX_LOG2);
        else
            return LOG_W'(code) + LOG_W'(1);
    endfunction

endpackage

// File: rtl/serclk_cfg.sv
// Configuration holding register. It follows the clock-select word and the
// polarity while the generator is stopped and freezes them while it runs.
// Assumes hold is the registered run-state of the generator.
module serclk_cfg
    import serclk_pkg::*;
#(
    parameter int SEL_W = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel_word,
    input  logic             pol_in,
    output sck_cfg_t         cfg,
    output logic             one_mode
);

    localparam logic [SEL_W-1:0] PRE_MASK  = SEL_W'({PRE_W{1'b1}}) << PRE_LSB;
    localparam logic [SEL_W-1:0] CODE_MASK = SEL_W'({CODE_W{1'b1}}) << CODE_LSB;
    localparam logic [SEL_W-1:0] USED_MASK = PRE_MASK | CODE_MASK;

    logic unused_sel_bits;
    assign unused_sel_bits = ^(sel_word & ~USED_MASK);

    // Capture config while stopped, freeze it while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (!hold) begin
            cfg.pre_m1 <= sel_word[PRE_LSB +: PRE_W];
            cfg.log2   <= code_to_log2(sel_word[CODE_LSB +: CODE_W]);
            cfg.pol    <= pol_in;
        end
    end

    // Ratio of one: prescale 1 and divider bypassed.
    always_comb begin
        one_mode = (cfg.pre_m1 == '0) && (cfg.log2 == '0);
    end

    // R9: config never moves while the generator was running on the previous edge
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> $stable(cfg));

endmodule

// File: rtl/serclk_count.sv
// Two-stage position counter: a prescaler and a power-of-two divider behind it.
// It flags the period start, the half point and the last cycle of each SCK period.
// Assumes the counters are held at zero while the generator is stopped.
module serclk_count
    import serclk_pkg::*;
#(
    parameter int P_W = PRE_W,
    parameter int L_W = LOG_W,
    parameter int D_W = DIV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic [P_W-1:0] pre_m1,
    input  logic [L_W-1:0] log2,
    output logic           at_zero,
    output logic           at_half,
    output logic           at_end
);

    logic [P_W-1:0] pc;
    logic [D_W-1:0] dc;
    logic [D_W:0]   d_ratio;
    logic [D_W-1:0] d_max;
    logic [D_W-1:0] d_half;
    logic [P_W:0]   p_ratio;
    logic [P_W-1:0] p_half;

    // Derived terminal and half-way counts for the latched ratio.
    always_comb begin
        d_ratio = (D_W+1)'(1) << log2;
        d_max   = D_W'(d_ratio - (D_W+1)'(1));
        d_half  = D_W'(d_ratio >> 1);
        p_ratio = {1'b0, pre_m1} + (P_W+1)'(1);
        p_half  = P_W'(p_ratio >> 1);
    end

    // Prescaler stage: counts peripheral cycles within one divider step.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            pc <= '0;
        end else if (pc == pre_m1) begin
            pc <= '0;
        end else begin
            pc <= pc + P_W'(1);
        end
    end

    // Divider stage: counts prescaler wraps within one SCK period.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            dc <= '0;
        end else if (pc == pre_m1) begin
            dc <= (dc == d_max) ? '0 : dc + D_W'(1);
        end
    end

    // Period position decode.
    always_comb begin
        at_zero = (pc == '0) && (dc == '0);
        at_end  = (pc == pre_m1) && (dc == d_max);
        if (log2 == '0)
            at_half = (pc == p_half);
        else
            at_half = (dc == d_half) && (pc == '0);
    end

    // R2: prescaler position never exceeds the latched prescale
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> pc <= pre_m1);

    // R2: divider position never exceeds the latched divide ratio
    a_r2_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> dc <= d_max);

endmodule

// File: rtl/serclk_wave.sv
// SCK waveform and edge strobes. For ratios of two or more it drives a
// registered SCK that toggles at the period start and at the half point. For a
// ratio of one it gates the peripheral clock through an enable that changes
// only while the clock is low.
// Assumes at_zero/at_half come from counters that are held at zero while stopped.
module serclk_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic one_mode,
    input  logic pol,
    input  logic at_zero,
    input  logic at_half,
    output logic sck,
    output logic rise_stb,
    output logic fall_stb,
    output logic bit_tick
);

    logic sck_q;
    logic gate_q;
    logic lead;
    logic trail;

    // Edge events of the divided waveform.
    always_comb begin
        lead  = at_zero;
        trail = at_half && !at_zero;
    end

    // Registered SCK level and its edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            bit_tick <= 1'b0;
        end else if (!active) begin
            sck_q    <= pol;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            bit_tick <= 1'b0;
        end else if (one_mode) begin
            sck_q    <= pol;
            rise_stb <= 1'b1;
            fall_stb <= 1'b1;
            bit_tick <= 1'b1;
        end else begin
            if (lead)
                sck_q <= ~pol;
            else if (trail)
                sck_q <= pol;
            rise_stb <= (lead && !pol) || (trail && pol);
            fall_stb <= (lead && pol) || (trail && !pol);
            bit_tick <= trail;
        end
    end

    // Clock-gate enable, updated while the clock is low so pulses stay whole.
    always_ff @(negedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= active && one_mode;
    end

    // Pin select: gated clock for a ratio of one, register otherwise.
    always_comb begin
        if (one_mode)
            sck = pol ^ (clk & gate_q);
        else
            sck = sck_q;
    end

    // R7: both strobes together only when running at a ratio of one
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && fall_stb) |-> one_mode);

    // R7: a rising strobe coincides with SCK at the high level
    a_r7_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && !one_mode) |-> sck_q);

    // R8: the tick marks the return of SCK to the idle level
    a_r8_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !one_mode) |-> (sck_q == pol));

endmodule

// File: rtl/serclk_gen.sv
// Prescaled serial clock generator top. It holds the run state, starts on run
// when stopped, and stops only at the end of an SCK period.
// Assumes clk_sel and cpol come from a register block and may change at any time.
module serclk_gen
    import serclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] clk_sel,
    input  logic             run,
    input  logic             cpol,
    output logic             sck,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             bit_tick
);

    logic     active;
    logic     one_mode;
    logic     at_zero;
    logic     at_half;
    logic     at_end;
    sck_cfg_t cfg;

    // Run state: start on run, stop only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (!active && run)
            active <= 1'b1;
        else if (active && !run && at_end)
            active <= 1'b0;
    end

    serclk_cfg #(.SEL_W(REG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (active),
        .sel_word (clk_sel),
        .pol_in   (cpol),
        .cfg      (cfg),
        .one_mode (one_mode)
    );

    serclk_count #(.P_W(PRE_W), .L_W(LOG_W), .D_W(DIV_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .pre_m1  (cfg.pre_m1),
        .log2    (cfg.log2),
        .at_zero (at_zero),
        .at_half (at_half),
        .at_end  (at_end)
    );

    serclk_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .one_mode (one_mode),
        .pol      (cfg.pol),
        .at_zero  (at_zero),
        .at_half  (at_half),
        .sck      (sck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .bit_tick (bit_tick)
    );

    // R10: two stopped cycles in a row produce no strobe or tick
    a_r10_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (!rise_stb && !fall_stb && !bit_tick));

    // R5: the edge after the start edge always produces an SCK edge strobe
    a_r5_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |=> (rise_stb || fall_stb));

endmodule

// File: tb/tb_serclk_gen.sv
// Directed bench for the prescaled serial clock generator.
module tb_serclk_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] clk_sel;
    logic        run;
    logic        cpol;
    logic        sck;
    logic        rise_stb;
    logic        fall_stb;
    logic        bit_tick;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    serclk_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (clk_sel),
        .run      (run),
        .cpol     (cpol),
        .sck      (sck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .bit_tick (bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int pre, input int code);
        int d;
        case (code)
            0: d = 2;
            1: d = 4;
            2: d = 8;
            3: d = 16;
            4, 5, 6: d = 32;
            default: d = 1;
        endcase
        return pre * d;
    endfunction

    function automatic logic [15:0] word_of(input int pre, input int code);
        return {3'b000, 5'(pre - 1), 5'b00000, 3'(code)};
    endfunction

    // R1: reset state of all outputs
    task automatic t_reset();
        rst_n = 1'b0; run = 1'b0; cpol = 1'b0; clk_sel = '0;
        repeat (4) @(negedge clk);
        check(sck === 1'b0 && rise_stb === 1'b0 && fall_stb === 1'b0 && bit_tick === 1'b0,
              "R1 outputs in reset", {sck, rise_stb, fall_stb, bit_tick}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sck === 1'b0 && rise_stb === 1'b0 && fall_stb === 1'b0 && bit_tick === 1'b0,
              "R1 outputs after reset", {sck, rise_stb, fall_stb, bit_tick}, 0);
    endtask

    // Waveform, strobes and tick against the expected pattern (R5, R6, R7, R8).
    task automatic run_pattern(input int pre, input int code, input bit pol,
                               input int periods, input string req);
        int n, h, err_s, err_r, err_t;
        bit prev, exp_s, exp_r, exp_f, exp_t, act;
        @(negedge clk);
        clk_sel = word_of(pre, code); cpol = pol; run = 1'b0;
        repeat (3) @(negedge clk);
        n = ratio_of(pre, code); h = n / 2;
        err_s = 0; err_r = 0; err_t = 0; prev = pol;
        run = 1'b1;
        for (int i = 0; i <= periods * n; i++) begin
            @(negedge clk);
            act   = (i >= 1) && (((i - 1) % n) < h);
            exp_s = act ? ~pol : pol;
            exp_r = exp_s && !prev;
            exp_f = !exp_s && prev;
            exp_t = (i >= 1) && (((i - 1) % n) == h);
            if (sck !== exp_s) err_s++;
            if (rise_stb !== exp_r || fall_stb !== exp_f) err_r++;
            if (bit_tick !== exp_t) err_t++;
            prev = exp_s;
        end
        run = 1'b0;
        repeat (n + 4) @(negedge clk);
        check(err_s == 0, {req, " R5 R6 sck waveform"}, err_s, 0);
        check(err_r == 0, {req, " R7 edge strobes"}, err_r, 0);
        check(err_t == 0, {req, " R8 bit tick"}, err_t, 0);
    endtask

    // R10: dropping run mid-period finishes the period, then stays idle.
    task automatic t_stop();
        int err;
        bit exp_s;
        @(negedge clk);
        clk_sel = word_of(2, 1); cpol = 1'b0; run = 1'b0;
        repeat (3) @(negedge clk);
        err = 0;
        run = 1'b1;
        for (int i = 0; i <= 24; i++) begin
            @(negedge clk);
            exp_s = (i >= 1) && (i <= 8) && (((i - 1) % 8) < 4);
            if (sck !== exp_s) err++;
            if (i > 8 && (rise_stb !== 1'b0 || fall_stb !== 1'b0 || bit_tick !== 1'b0)) err++;
            if (i == 2) run = 1'b0;
        end
        check(err == 0, "R10 stop completes period then idles", err, 0);
    endtask

    // R9: writes during a run are ignored; the new value applies at the next start.
    task automatic t_freeze();
        int err;
        bit exp_s;
        @(negedge clk);
        clk_sel = word_of(1, 0); cpol = 1'b0; run = 1'b0;
        repeat (3) @(negedge clk);
        err = 0;
        run = 1'b1;
        for (int i = 0; i <= 20; i++) begin
            @(negedge clk);
            exp_s = (i >= 1) && (((i - 1) % 2) < 1);
            if (sck !== exp_s) err++;
            if (i == 3) begin
                clk_sel = word_of(4, 3);
                cpol = 1'b1;
            end
        end
        run = 1'b0;
        repeat (6) @(negedge clk);
        check(err == 0, "R9 config change while running ignored", err, 0);
        run_pattern(3, 0, 1'b1, 2, "R9 new config applies at next start");
    endtask

    // R11: ratio of one gives a gated clock with strobes held high.
    task automatic t_one(input bit pol);
        int err;
        bit exp_s;
        @(negedge clk);
        clk_sel = word_of(1, 7); cpol = pol; run = 1'b0;
        repeat (3) @(negedge clk);
        err = 0;
        run = 1'b1;
        for (int j = 1; j <= 6; j++) begin
            @(posedge clk);
            #2;
            exp_s = (j >= 2) ? ~pol : pol;
            if (sck !== exp_s) err++;
            @(negedge clk);
            if (sck !== pol) err++;
            exp_s = (j >= 2);
            if (rise_stb !== exp_s || fall_stb !== exp_s || bit_tick !== exp_s) err++;
        end
        run = 1'b0;
        @(posedge clk);
        #2;
        if (sck !== ~pol) err++;
        @(posedge clk);
        #2;
        if (sck !== pol) err++;
        @(negedge clk);
        if (rise_stb !== 1'b0 || fall_stb !== 1'b0 || bit_tick !== 1'b0) err++;
        repeat (3) @(negedge clk);
        if (sck !== pol) err++;
        check(err == 0, "R11 divide-by-one gated clock", err, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        run_pattern(1, 0, 1'b0, 3, "R2 ratio 2");
        run_pattern(1, 1, 1'b0, 2, "R2 ratio 4");
        run_pattern(1, 2, 1'b0, 2, "R2 ratio 8");
        run_pattern(1, 3, 1'b0, 2, "R2 ratio 16");
        run_pattern(1, 4, 1'b0, 2, "R2 ratio 32");
        run_pattern(3, 2, 1'b0, 2, "R2 ratio 3x8");
        run_pattern(32, 4, 1'b0, 1, "R2 ratio 1024");
        run_pattern(2, 1, 1'b1, 2, "R6 idle high ratio 8");
        run_pattern(1, 5, 1'b0, 2, "R3 code 5");
        run_pattern(2, 6, 1'b1, 1, "R3 code 6");
        run_pattern(3, 7, 1'b0, 3, "R4 bypass ratio 3");
        run_pattern(6, 7, 1'b1, 2, "R4 bypass ratio 6");
        run_pattern(2, 7, 1'b0, 3, "R4 bypass ratio 2");
        t_stop();
        t_freeze();
        t_one(1'b0);
        t_one(1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule